// File: doc/BRIEF.md
# Memory-Card Sector Read Sequencer

This block is a hardware master that fetches a run of 512-byte sectors from a memory-card controller on behalf of a processor. The processor hands it a starting logical block address and a number of blocks. The sequencer does all of the register traffic itself and streams the data bytes out on a valid/ready byte port. On the first request only, it programs the register-bus width mode. It then claims the card lock, waits until the card is present and ready for a command, and works through the request in chunks. For each chunk it programs the address and the count and holds the configuration logic in reset while it drains the sector buffer in bursts. Finally it releases the lock and reports the number of blocks read.

The controller is reached through a simple request/acknowledge register port. The port carries a 7-bit byte offset and 16-bit data, and each access stays on the port until it is acknowledged. Failures do not stop the block. If the lock is refused, the card is missing or the card never becomes ready, the sequencer finishes with a reported count of zero.

Top module: `sector_reader`

## Requirements
- R1: After reset, `req_ready` is 1 and `reg_req`, `out_valid` and `done_valid` are 0; a request is taken when `req_valid` and `req_ready` are both high on a clock edge, and `req_ready` stays low until the request has finished.
- R2: On the first request after reset only, the block writes the bus-width mode to offset 0x00: 0x0001 when `WIDE_BUS` is 1, otherwise 0x0000. Later requests do not write offset 0x00.
- R3: To take the lock, the block reads the control register at 0x18 and writes it back with bit 1 set and all other bits kept. It then reads status at 0x04 until bit 1 is set. After `LOCK_POLLS` status reads without the lock, it finishes with 0 blocks, does not write the control register again and reads no data.
- R4: Once the lock is held, a status read with bit 4 (card present) clear ends the wait. The block then writes the control register with bit 1 cleared and the other bits kept, and reports 0.
- R5: If bit 8 (ready for command) of status is still clear after `READY_POLLS` status reads, the block releases the lock as in R4 and reports 0.
- R6: The request is split into chunks of min(remaining, 256) blocks. For each chunk, the block writes address bits 15:0 to 0x10 and address bits 27:16 (upper nibble zero) to 0x12. After each chunk the address advances by the chunk size.
- R7: For each chunk, the block writes 0x0300 OR (chunk size mod 256) to 0x14, so a chunk of 256 blocks is written as 0x0300.
- R8: When `KEEP_CFG` is 0, each count write is followed by a write to 0x18 that sets bit 7 while keeping the other bits. After the chunk is drained, a write to 0x18 clears bit 7, whatever the setting of `KEEP_CFG`.
- R9: A chunk takes chunk×`ROUNDS_PER_BLK` rounds. In each round the block reads status until bit 5 (buffer ready) is set, then reads the data register at 0x40 `BURST` times.
- R10: Each data word goes out as two bytes, bits 7:0 first and bits 15:8 second. A byte stays on `out_data` with `out_valid` high until `out_ready` takes it, and no register access is made while a byte is waiting.
- R11: When all blocks are read, the block clears bit 1 of the control register, keeping the other bits. It then pulses `done_valid` for one cycle with `done_blocks` equal to the requested count. A request for zero blocks reads nothing and reports 0.
- R12: A register access keeps `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` unchanged until the cycle in which `reg_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_lba | input | LBA_W | Starting logical block address |
| req_count | input | CNT_W | Number of blocks to read |
| done_valid | output | 1 | One-cycle completion pulse |
| done_blocks | output | CNT_W | Blocks read, zero on error |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 for write, 0 for read |
| reg_addr | output | 7 | Register byte offset |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Access completes this cycle |
| reg_rdata | input | 16 | Read data, valid with reg_ack |
| out_valid | output | 1 | Data byte available |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Data byte |

## Verification
The embedded assertions cover the handshakes on every cycle: register accesses held until acknowledged, bytes held under backpressure, no register traffic while a byte waits, and the completion pulse with its return to idle. The exact order and values of the register writes, the split of a long request across the 256-block boundary, the read-modify-write that keeps foreign control bits, and the byte order and count of the data stream are checked only by the bench scenarios. The same holds for the three failure exits (lock refused, card missing, never ready). The bench compares a logged write sequence and byte stream against its own model of each request.

// File: rtl/sector_reader.sv
module sector_reader #(
  parameter int LBA_W          = 28,
  parameter int CNT_W          = 16,
  parameter int BURST          = 16,
  parameter int ROUNDS_PER_BLK = 16,
  parameter int LOCK_POLLS     = 10,
  parameter int LOCK_GAP       = 1000,
  parameter int READY_POLLS    = 2000,
  parameter int READY_GAP      = 100,
  parameter int BUF_GAP        = 4,
  parameter bit WIDE_BUS       = 1'b1,
  parameter bit KEEP_CFG       = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LBA_W-1:0] req_lba,
  input  logic [CNT_W-1:0] req_count,
  output logic             done_valid,
  output logic [CNT_W-1:0] done_blocks,
  output logic             reg_req,
  output logic             reg_we,
  output logic [6:0]       reg_addr,
  output logic [15:0]      reg_wdata,
  input  logic             reg_ack,
  input  logic [15:0]      reg_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data
);
  localparam int CHUNK_MAX = 256;
  localparam int RND_W     = $clog2(CHUNK_MAX * ROUNDS_PER_BLK + 1);
  localparam int BW        = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [6:0] OFS_MODE = 7'h00, OFS_STAT = 7'h04, OFS_LO = 7'h10,
                         OFS_HI = 7'h12, OFS_CMD = 7'h14, OFS_CTL = 7'h18, OFS_DAT = 7'h40;
  localparam logic [15:0] M_LOCK = 16'h0002, M_CRST = 16'h0080;

  typedef enum logic [4:0] {
    IDLE, MODE, LK_RD, LK_WR, LK_POLL, LK_WAIT, RY_POLL, RY_WAIT, CHUNK,
    AD_LO, AD_HI, CMD, RS_RD, RS_WR, BF_POLL, BF_WAIT, DATA, B_LO, B_HI,
    RC_RD, RC_WR, RL_RD, RL_WR, FIN
  } st_t;

  st_t              st;
  logic             mode_done;
  logic [LBA_W-1:0] lba;
  logic [CNT_W-1:0] remain, total, result;
  logic [8:0]       trans;
  logic [15:0]      ctl, word, tries;
  logic [31:0]      gap;
  logic [RND_W-1:0] rnd;
  logic [BW-1:0]    widx;
  logic [8:0]       trans_next;

  assign trans_next  = (remain > CNT_W'(CHUNK_MAX)) ? 9'(CHUNK_MAX) : 9'(remain);
  assign req_ready   = (st == IDLE);
  assign done_valid  = (st == FIN);
  assign done_blocks = result;
  assign out_valid   = (st == B_LO) || (st == B_HI);
  assign out_data    = (st == B_HI) ? word[15:8] : word[7:0];

  always_comb begin
    reg_req   = 1'b1;
    reg_we    = 1'b0;
    reg_addr  = OFS_STAT;
    reg_wdata = 16'h0000;
    case (st)
      MODE:                       begin reg_we = 1'b1; reg_addr = OFS_MODE; reg_wdata = WIDE_BUS ? 16'h0001 : 16'h0000; end
      LK_RD, RS_RD, RC_RD, RL_RD: reg_addr = OFS_CTL;
      LK_WR:                      begin reg_we = 1'b1; reg_addr = OFS_CTL; reg_wdata = ctl | M_LOCK; end
      RS_WR:                      begin reg_we = 1'b1; reg_addr = OFS_CTL; reg_wdata = ctl | M_CRST; end
      RC_WR:                      begin reg_we = 1'b1; reg_addr = OFS_CTL; reg_wdata = ctl & ~M_CRST; end
      RL_WR:                      begin reg_we = 1'b1; reg_addr = OFS_CTL; reg_wdata = ctl & ~M_LOCK; end
      LK_POLL, RY_POLL, BF_POLL:  reg_addr = OFS_STAT;
      AD_LO:                      begin reg_we = 1'b1; reg_addr = OFS_LO; reg_wdata = lba[15:0]; end
      AD_HI:                      begin reg_we = 1'b1; reg_addr = OFS_HI; reg_wdata = 16'(lba[LBA_W-1:16]) & 16'h0fff; end
      CMD:                        begin reg_we = 1'b1; reg_addr = OFS_CMD; reg_wdata = {8'h03, trans[7:0]}; end
      DATA:                       reg_addr = OFS_DAT;
      default:                    reg_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; mode_done <= 1'b0; lba <= '0; remain <= '0; total <= '0;
      result <= '0; trans <= '0; ctl <= '0; word <= '0; tries <= '0;
      gap <= '0; rnd <= '0; widx <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          lba <= req_lba; remain <= req_count; total <= req_count;
          st <= mode_done ? LK_RD : MODE;
        end
        MODE:  if (reg_ack) begin mode_done <= 1'b1; st <= LK_RD; end
        LK_RD: if (reg_ack) begin ctl <= reg_rdata; st <= LK_WR; end
        LK_WR: if (reg_ack) begin ctl <= ctl | M_LOCK; tries <= '0; st <= LK_POLL; end
        LK_POLL: if (reg_ack) begin
          if (reg_rdata[1]) begin tries <= '0; st <= RY_POLL; end
          else if (tries == 16'(LOCK_POLLS - 1)) begin result <= '0; st <= FIN; end
          else begin tries <= tries + 1'b1; gap <= '0; st <= LK_WAIT; end
        end
        LK_WAIT: if (gap == 32'(LOCK_GAP - 1)) st <= LK_POLL; else gap <= gap + 1;
        RY_POLL: if (reg_ack) begin
          if (!reg_rdata[4]) begin result <= '0; st <= RL_RD; end
          else if (reg_rdata[8]) st <= CHUNK;
          else if (tries == 16'(READY_POLLS - 1)) begin result <= '0; st <= RL_RD; end
          else begin tries <= tries + 1'b1; gap <= '0; st <= RY_WAIT; end
        end
        RY_WAIT: if (gap == 32'(READY_GAP - 1)) st <= RY_POLL; else gap <= gap + 1;
        CHUNK:
          if (remain == '0) begin result <= total; st <= RL_RD; end
          else begin trans <= trans_next; st <= AD_LO; end
        AD_LO: if (reg_ack) st <= AD_HI;
        AD_HI: if (reg_ack) st <= CMD;
        CMD:   if (reg_ack) begin rnd <= '0; st <= KEEP_CFG ? BF_POLL : RS_RD; end
        RS_RD: if (reg_ack) begin ctl <= reg_rdata; st <= RS_WR; end
        RS_WR: if (reg_ack) begin ctl <= ctl | M_CRST; st <= BF_POLL; end
        BF_POLL: if (reg_ack) begin
          if (reg_rdata[5]) begin widx <= '0; st <= DATA; end
          else begin gap <= '0; st <= BF_WAIT; end
        end
        BF_WAIT: if (gap == 32'(BUF_GAP - 1)) st <= BF_POLL; else gap <= gap + 1;
        DATA:  if (reg_ack) begin word <= reg_rdata; st <= B_LO; end
        B_LO:  if (out_ready) st <= B_HI;
        B_HI:  if (out_ready) begin
          if (widx != BW'(BURST - 1)) begin widx <= widx + 1'b1; st <= DATA; end
          else if (32'(rnd) == 32'(trans) * 32'(ROUNDS_PER_BLK) - 1) st <= RC_RD;
          else begin rnd <= rnd + 1'b1; st <= BF_POLL; end
        end
        RC_RD: if (reg_ack) begin ctl <= reg_rdata; st <= RC_WR; end
        RC_WR: if (reg_ack) begin
          ctl <= ctl & ~M_CRST;
          lba <= lba + LBA_W'(trans);
          remain <= remain - CNT_W'(trans);
          st <= CHUNK;
        end
        RL_RD: if (reg_ack) begin ctl <= reg_rdata; st <= RL_WR; end
        RL_WR: if (reg_ack) st <= FIN;
        FIN:   st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assert_hold_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));
  assert_hold_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !reg_req);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready);
  assert_busy_after_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
endmodule

// File: tb/sector_reader_test.sv
module sector_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int RPB = 1;
  localparam int LPOLLS = 10;
  localparam int RPOLLS = 20;
  localparam logic [15:0] CTL0 = 16'h4401;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [27:0] req_lba = '0;
  logic [15:0] req_count = '0;
  logic done_valid; logic [15:0] done_blocks;
  logic reg_req, reg_we, reg_ack = 0; logic [6:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata = '0;
  logic out_valid, out_ready = 0; logic [7:0] out_data;

  sector_reader #(.LOCK_POLLS(LPOLLS), .LOCK_GAP(8), .READY_POLLS(RPOLLS), .READY_GAP(2),
                  .BUF_GAP(2), .ROUNDS_PER_BLK(RPB)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] mctl = CTL0;
  bit lock_ok = 1, present = 1, ready_ok = 1;
  int nw = 0, ndata = 0, nstat = 0, hold_bad = 0, busy_bad = 0;
  logic [6:0] wa [64]; logic [15:0] wd [64];
  logic [7:0] got [$];
  bit done_seen = 0; logic [15:0] done_val = '0;
  bit pend = 0; logic [6:0] p_a; logic [15:0] p_d; logic p_w;

  function automatic logic [15:0] dw(int i);
    return 16'((i * 40503 + 12345) & 32'hFFFF);
  endfunction

  function automatic logic [15:0] stat_word();
    logic [15:0] s = '0;
    s[1] = mctl[1] && lock_ok;
    s[4] = present;
    s[8] = ready_ok && (nstat >= 3);
    s[5] = ($urandom % 4) != 0;
    return s;
  endfunction

  always @(negedge clk) begin
    if (pend) begin
      if (!(reg_req && reg_addr == p_a && reg_we == p_w && reg_wdata == p_d)) hold_bad++;
      pend = 0;
    end
    if (reg_req && out_valid) busy_bad++;
    if (reg_req && !reg_ack && ($urandom % 2 == 0)) begin
      reg_ack = 1;
      if (reg_we) begin
        if (nw < 64) begin wa[nw] = reg_addr; wd[nw] = reg_wdata; end
        nw++;
        if (reg_addr == 7'h18) mctl = reg_wdata;
      end else begin
        case (reg_addr)
          7'h04: begin reg_rdata = stat_word(); nstat++; end
          7'h18: reg_rdata = mctl;
          7'h40: begin reg_rdata = dw(ndata); ndata++; end
          default: reg_rdata = 16'hDEAD;
        endcase
      end
    end else begin
      if (reg_req && !reg_ack) begin pend = 1; p_a = reg_addr; p_w = reg_we; p_d = reg_wdata; end
      reg_ack = 0;
    end
    begin
      logic r = ($urandom % 4) != 0;
      if (out_valid && r) got.push_back(out_data);
      out_ready = r;
    end
    if (done_valid) begin done_seen = 1; done_val = done_blocks; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [27:0] lba, input logic [15:0] cnt, input int kind, input bit first);
    logic [6:0] ea [64]; logic [15:0] ed [64];
    int ne = 0, wait_c = 0, bad_i = -1, nbytes, bbad = -1;
    logic [15:0] c = mctl;
    logic [27:0] a = lba;
    int rem = cnt;
    lock_ok = (kind != 1); present = (kind != 2); ready_ok = (kind != 3);
    nw = 0; ndata = 0; nstat = 0; hold_bad = 0; busy_bad = 0; got.delete(); done_seen = 0;
    @(negedge clk); req_valid = 1; req_lba = lba; req_count = cnt;
    @(negedge clk); req_valid = 0;
    chk(req_ready == 0, "R1 busy after accept", req_ready, 0);
    while (!done_seen && wait_c < 150000) begin @(negedge clk); wait_c++; end
    chk(done_seen, "watchdog: no completion", done_seen, 1);
    if (first) begin ea[ne] = 7'h00; ed[ne] = 16'h0001; ne++; end
    ea[ne] = 7'h18; ed[ne] = c | 16'h0002; ne++;
    if (kind == 0) begin
      while (rem > 0) begin
        int t = (rem > 256) ? 256 : rem;
        ea[ne] = 7'h10; ed[ne] = a[15:0]; ne++;
        ea[ne] = 7'h12; ed[ne] = {4'h0, a[27:16]}; ne++;
        ea[ne] = 7'h14; ed[ne] = 16'h0300 | 16'(t & 8'hFF); ne++;
        ea[ne] = 7'h18; ed[ne] = c | 16'h0082; ne++;
        ea[ne] = 7'h18; ed[ne] = c | 16'h0002; ne++;
        a = a + 28'(t); rem -= t;
      end
    end
    if (kind != 1) begin ea[ne] = 7'h18; ed[ne] = c & ~16'h0002; ne++; end
    chk(done_val == ((kind == 0) ? cnt : 16'h0), "R11 done_blocks", done_val, (kind == 0) ? cnt : 0);
    chk(nw == ne, "R3/R6/R8 write count", nw, ne);
    for (int i = 0; i < ne && i < nw; i++)
      if (bad_i < 0 && (wa[i] != ea[i] || wd[i] != ed[i])) bad_i = i;
    chk(bad_i < 0, "R2/R6/R7/R8 write sequence", (bad_i < 0) ? 0 : {wa[bad_i], wd[bad_i]},
        (bad_i < 0) ? 0 : {ea[bad_i], ed[bad_i]});
    nbytes = (kind == 0) ? cnt * RPB * 16 * 2 : 0;
    chk(ndata == nbytes / 2, "R9 data reads", ndata, nbytes / 2);
    chk(got.size() == nbytes, "R10 byte count", got.size(), nbytes);
    for (int k = 0; k < got.size() && k < nbytes; k++) begin
      logic [15:0] w = dw(k / 2);
      logic [7:0] e = (k % 2 == 0) ? w[7:0] : w[15:8];
      if (bbad < 0 && got[k] != e) bbad = k;
    end
    chk(bbad < 0, "R10 byte order/content", bbad, -1);
    chk(hold_bad == 0, "R12 access held until ack", hold_bad, 0);
    chk(busy_bad == 0, "R10 no access while byte pending", busy_bad, 0);
    if (kind == 1) chk(nstat == LPOLLS, "R3 lock poll limit", nstat, LPOLLS);
    if (kind == 3) chk(nstat == 1 + RPOLLS, "R5 ready poll limit", nstat, 1 + RPOLLS);
    if (kind == 2) chk(nstat == 2, "R4 absent ends wait", nstat, 2);
    if (kind == 1) mctl = c;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 reset req_ready", req_ready, 1);
    chk(reg_req == 0 && out_valid == 0 && done_valid == 0, "R1 reset outputs",
        {reg_req, out_valid, done_valid}, 0);
    run(28'h0ABCDEF, 16'd3, 0, 1);
    run(28'h00FFF80, 16'd300, 0, 0);
    run(28'h1234567, 16'd0, 0, 0);
    run(28'h0000100, 16'd2, 1, 0);
    run(28'h0000100, 16'd2, 2, 0);
    run(28'h0000100, 16'd2, 3, 0);
    run(28'hFFFFFFF, 16'd1, 0, 0);
    for (int j = 0; j < 3; j++)
      run(28'($urandom), 16'($urandom % 6), 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule